// File: doc/BRIEF.md
# Page Write Buffer with Top-Quarter Write Protection

This block sits behind the serial slave engine of a small byte-addressed nonvolatile memory. During a write command the slave engine tells it when a start condition was seen, hands over the two-byte target address once the second address byte has been received, and then passes each data byte with a strobe. The bytes are held in a 32-entry page latch whose slot index starts at the low five bits of the target address and advances modulo 32, so a long burst wraps inside one row and later bytes replace earlier ones.

When the engine reports a stop condition that fell in the slot right after an acknowledge, the block commits: it raises a busy flag for a fixed number of system clock cycles, and during that time it walks the page latch and issues one array write for each slot that actually received a byte. A stop anywhere else, a repeated start, or a command with no data discards the latch. The slave engine uses the busy flag to refuse acknowledges; the block itself ignores every command input while busy.

A write-control pin level is sampled from the start condition up to and including the cycle in which the address is delivered. If it was high in any of those cycles, committed bytes whose address lies in the top quarter of the array are dropped, while bytes elsewhere are still written. The array starts as all ones and has a combinational read port that does not look at the write-control pin.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy is low, no array write is issued, and every array byte reads FFh.
- R2: A received byte is stored at row = load address bits above bit 4, slot = (low 5 bits of load address + byte index) mod 32; the row bits never change within a command and a later byte landing in the same slot replaces the earlier one.
- R3: Only slots that received a byte are written: the number of array write pulses in a commit equals the number of distinct slots received.
- R4: A commit happens only when the stop-after-acknowledge strobe arrives in the data phase with at least one byte received; a stop at another point, a repeated start, or an empty command writes nothing and leaves busy low.
- R5: Busy goes high in the cycle after the committing stop and stays high for exactly WR_CYCLES cycles; array write pulses occur only while busy is high.
- R6: While busy, start, address, data and stop strobes are ignored: they change no array byte and do not extend or restart the write cycle.
- R7: If the write-control level is high in any cycle from the start strobe through the address strobe inclusive, committed bytes whose address has its two top bits equal to 11 (0x180 to 0x1FF at the default 9-bit address) are not written.
- R8: The write-control level during the data phase has no effect, and bytes outside the top quarter are written whatever the write-control level was.
- R9: The read port returns array contents independently of the write-control level.
- R10: Data strobes that arrive after the start strobe but before the address strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | One-cycle pulse: start condition of a new command |
| addr_load | input | 1 | One-cycle pulse: both address bytes received |
| addr_in | input | ADDR_W | Target byte address, valid with addr_load |
| wr_protect | input | 1 | Write-control pin level (high protects the top quarter) |
| byte_valid | input | 1 | One-cycle pulse: a data byte was received |
| byte_data | input | 8 | Data byte, valid with byte_valid |
| stop_acked | input | 1 | Stop condition in the slot right after an acknowledge |
| stop_other | input | 1 | Stop condition at any other point |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write request |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | 8 | Read port data (combinational) |

## Verification
The assertions assume the slave engine delivers each strobe as a single-cycle pulse, never raises more than one of start, address, data and stop in the same cycle, and only issues the address strobe after a start. The bench keeps inside that contract by driving exactly one event per clock cycle on the falling edge, always in the order start, idle, address, data bytes, end event. Deliberate protocol faults such as data before the address or strobes during busy are still single events per cycle, so the assumptions hold while the block's filtering of those faults is exercised.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/pwb_cmd_track.sv
module pwb_cmd_track
  import pwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cmd_start,
  input  logic addr_load,
  input  logic wc_level,
  input  logic stop_ack,
  input  logic stop_other,
  output logic in_addr,
  output logic in_data,
  output logic prot
);
  phase_e ph_q, ph_d;
  logic   prot_q, prot_d;

  always_comb begin
    ph_d   = ph_q;
    prot_d = prot_q;
    if (!busy) begin
      if (cmd_start) begin
        ph_d   = PH_ADDR;
        prot_d = wc_level;
      end else if (stop_ack || stop_other) begin
        ph_d = PH_IDLE;
      end else if (ph_q == PH_ADDR) begin
        prot_d = prot_q | wc_level;
        if (addr_load) ph_d = PH_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      prot_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      prot_q <= prot_d;
    end
  end

  assign in_addr = (ph_q == PH_ADDR);
  assign in_data = (ph_q == PH_DATA);
  assign prot    = prot_q;

  // R7
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !cmd_start) |=> $stable(prot_q));

  // R6
  busy_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ph_q));
endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 9,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int ROW_W     = ADDR_W - SLOT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     load_addr,
  input  logic                  put,
  input  logic [7:0]            put_data,
  input  logic                  release_i,
  input  logic [SLOT_W-1:0]     sel,
  output logic [ROW_W-1:0]      row,
  output logic [PAGE_BYTES-1:0] mask,
  output logic [7:0]            sel_data
);
  logic [ROW_W-1:0]      row_q, row_d;
  logic [SLOT_W-1:0]     off_q, off_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [7:0]            data_q [PAGE_BYTES];

  always_comb begin
    row_d  = row_q;
    off_d  = off_q;
    mask_d = mask_q;
    if (clear || release_i) begin
      mask_d = '0;
    end else if (load) begin
      row_d  = load_addr[ADDR_W-1:SLOT_W];
      off_d  = load_addr[SLOT_W-1:0];
      mask_d = '0;
    end else if (put) begin
      mask_d[off_q] = 1'b1;
      off_d         = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else begin
      row_q  <= row_d;
      off_q  <= off_d;
      mask_q <= mask_d;
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic slot_en;
    assign slot_en = put && !clear && !load && !release_i && (off_q == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (slot_en) data_q[s] <= put_data;
    end
  end

  assign row      = row_q;
  assign mask     = mask_q;
  assign sel_data = data_q[sel];

  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!put && !load) |=> $stable(off_q));

  // R3
  mask_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !release_i && !load) |=>
      ($countones(mask_q) <= $countones($past(mask_q)) + 1));
endmodule

// File: rtl/pwb_write_seq.sv
module pwb_write_seq #(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 9,
  parameter int WR_CYCLES  = 40,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int ROW_W     = ADDR_W - SLOT_W,
  localparam int TMR_W     = $clog2(WR_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [ROW_W-1:0]      row,
  input  logic                  prot,
  input  logic [PAGE_BYTES-1:0] mask,
  input  logic [7:0]            sel_data,
  output logic                  busy,
  output logic                  done,
  output logic [SLOT_W-1:0]     sel,
  output logic                  we,
  output logic [ADDR_W-1:0]     waddr,
  output logic [7:0]            wdata
);
  logic              busy_q, busy_d;
  logic [TMR_W-1:0]  timer_q, timer_d;
  logic [SLOT_W:0]   scan_q, scan_d;
  logic              we_q, we_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic              locked, scanning;

  assign locked   = prot && (row[ROW_W-1 -: 2] == 2'b11);
  assign scanning = busy_q && !scan_q[SLOT_W];

  always_comb begin
    busy_d  = busy_q;
    timer_d = timer_q;
    scan_d  = scan_q;
    if (go) begin
      busy_d  = 1'b1;
      timer_d = TMR_W'(WR_CYCLES - 1);
      scan_d  = '0;
    end else if (busy_q) begin
      if (timer_q == '0) busy_d = 1'b0;
      else               timer_d = timer_q - 1'b1;
      if (scanning) scan_d = scan_q + 1'b1;
    end
    we_d    = scanning && mask[scan_q[SLOT_W-1:0]] && !locked;
    waddr_d = {row, scan_q[SLOT_W-1:0]};
    wdata_d = sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
      scan_q  <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      timer_q <= timer_d;
      scan_q  <= scan_d;
      we_q    <= we_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy  = busy_q;
  assign done  = busy_q && (timer_q == '0);
  assign sel   = scan_q[SLOT_W-1:0];
  assign we    = we_q;
  assign waddr = waddr_q;
  assign wdata = wdata_q;

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> busy_q);

  // R5
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (timer_q == TMR_W'(WR_CYCLES - 1)));

  // R7
  locked_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> !(prot && waddr_q[ADDR_W-1 -: 2] == 2'b11));

  // R3
  we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> mask[waddr_q[SLOT_W-1:0]]);
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 40,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int ROW_W     = ADDR_W - SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_protect,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              stop_acked,
  input  logic              stop_other,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0]            rst_sync_q;
  logic                  rst_i_n;
  logic                  in_addr, in_data, prot;
  logic                  clear, load, put, go, done;
  logic [ROW_W-1:0]      row;
  logic [PAGE_BYTES-1:0] mask;
  logic [SLOT_W-1:0]     sel;
  logic [7:0]            sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign clear = cmd_start && !busy;
  assign load  = addr_load && in_addr && !busy && !cmd_start;
  assign put   = byte_valid && in_data && !busy && !cmd_start;
  assign go    = stop_acked && in_data && (|mask) && !busy && !cmd_start;

  pwb_cmd_track u_track (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .busy       (busy),
    .cmd_start  (cmd_start),
    .addr_load  (addr_load),
    .wc_level   (wr_protect),
    .stop_ack   (stop_acked),
    .stop_other (stop_other),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .prot       (prot)
  );

  pwb_page_latch #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (clear),
    .load      (load),
    .load_addr (addr_in),
    .put       (put),
    .put_data  (byte_data),
    .release_i (done),
    .sel       (sel),
    .row       (row),
    .mask      (mask),
    .sel_data  (sel_data)
  );

  pwb_write_seq #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .go       (go),
    .row      (row),
    .prot     (prot),
    .mask     (mask),
    .sel_data (sel_data),
    .busy     (busy),
    .done     (done),
    .sel      (sel),
    .we       (arr_we),
    .waddr    (arr_waddr),
    .wdata    (arr_wdata)
  );

  pwb_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R4
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> $past(stop_acked));
endmodule

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 9;
  localparam int PB    = 32;
  localparam int WRC   = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, addr_load, wr_protect, byte_valid, stop_acked, stop_other;
  logic [AW-1:0] addr_in, rd_addr, arr_waddr;
  logic [7:0] byte_data, arr_wdata, rd_data;
  logic busy, arr_we;

  int tests = 0, fails = 0, we_cnt = 0, we_out = 0;
  bit finished = 0;
  logic [7:0] exp_mem [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  page_write_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .addr_load(addr_load),
    .addr_in(addr_in), .wr_protect(wr_protect), .byte_valid(byte_valid),
    .byte_data(byte_data), .stop_acked(stop_acked), .stop_other(stop_other),
    .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (arr_we) begin
    we_cnt++;
    if (!busy) we_out++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cyc(input bit cs, input bit al, input int a, input bit bv,
                     input int bd, input bit sa, input bit so, input bit wc);
    @(negedge clk);
    cmd_start = cs; addr_load = al; addr_in = a[AW-1:0]; byte_valid = bv;
    byte_data = bd[7:0]; stop_acked = sa; stop_other = so; wr_protect = wc;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // Counts busy cycles starting the cycle after the last driven event.
  task automatic wait_busy(output int cnt);
    cnt = 0;
    idle();
    #1;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check_array(input string req, input bit wc_lvl);
    int errs = 0;
    int bad_a = 0, bad_v = 0, bad_e = 0;
    wr_protect = wc_lvl;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = a[AW-1:0];
      #1;
      if (rd_data !== exp_mem[a]) begin
        if (errs == 0) begin bad_a = a; bad_v = rd_data; bad_e = exp_mem[a]; end
        errs++;
      end
    end
    wr_protect = 1'b0;
    tests++;
    if (errs != 0) begin
      fails++;
      $display("FAIL %s array addr=%0h actual=%0h expected=%0h (%0d mismatches)",
               req, bad_a, bad_v, bad_e, errs);
    end
  endtask

  function automatic int dbyte(input int seed, input int i);
    return (seed * 13 + i * 7 + 1) & 255;
  endfunction

  // endk: 0 stop after ack, 1 other stop, 2 restart then other stop
  task automatic run_write(input int addr, input int n, input int seed,
                           input bit wcs, input bit wcm, input bit wcl,
                           input bit wcd, input int endk, input string req);
    bit [PB-1:0] got;
    int cnt, nslots, off, row;
    bit lock, commit;
    we_cnt = 0;
    got = '0;
    off = addr % PB;
    row = addr / PB;
    cyc(1, 0, 0, 0, 0, 0, 0, wcs);
    cyc(0, 0, 0, 0, 0, 0, 0, wcm);
    cyc(0, 1, addr, 0, 0, 0, 0, wcl);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, dbyte(seed, i), 0, 0, wcd);
    if (endk == 0)      cyc(0, 0, 0, 0, 0, 1, 0, wcd);
    else if (endk == 1) cyc(0, 0, 0, 0, 0, 0, 1, wcd);
    else begin
      cyc(1, 0, 0, 0, 0, 0, 0, wcd);
      cyc(0, 0, 0, 0, 0, 0, 1, 0);
    end
    wait_busy(cnt);
    commit = (endk == 0) && (n > 0);
    lock   = (wcs | wcm | wcl) && (((addr >> (AW - 2)) & 3) == 3);
    check(cnt == (commit ? WRC : 0), {req, " R5/R4 busy length"}, cnt, commit ? WRC : 0);
    for (int i = 0; i < n; i++) got[(off + i) % PB] = 1'b1;
    nslots = $countones(got);
    if (commit && !lock)
      for (int i = 0; i < n; i++) exp_mem[row * PB + (off + i) % PB] = dbyte(seed, i)[7:0];
    check(we_cnt == ((commit && !lock) ? nslots : 0), {req, " R3 write pulses"},
          we_cnt, (commit && !lock) ? nslots : 0);
    check_array(req, 1'b0);
  endtask

  initial begin
    #(CLK_P * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int cnt;
    rst_n = 1'b0;
    cmd_start = 0; addr_load = 0; addr_in = '0; wr_protect = 0; byte_valid = 0;
    byte_data = '0; stop_acked = 0; stop_other = 0; rd_addr = '0;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(arr_we == 1'b0, "R1 no write after reset", arr_we, 0);
    check_array("R1 initial contents", 1'b0);

    // R2 sweep of start slot and length; wc high in data phase only (R8)
    for (int off = 0; off < PB; off++) begin
      for (int k = 0; k < 4; k++) begin
        int n, row;
        n   = (k == 0) ? 1 : (k == 1) ? PB - off : (k == 2) ? PB + 1 - off : PB + 5;
        row = (off + k * 5) % (DEPTH / PB);
        run_write(row * PB + off, n, off * 4 + k, 0, 0, 0, k[0], 0, "R2 R8 sweep");
      end
    end

    // R7 protection window matrix, R8 unprotected rows
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 3; r++) begin
        int row;
        row = (r == 0) ? 3 : (r == 1) ? 13 : 15;
        run_write(row * PB + p * 3, 4, 100 + p * 3 + r, p[0], p[1], p[2], 0, 0,
                  "R7 R8 protect window");
      end
    end

    // R9 read port with wc high
    check_array("R9 read with wc high", 1'b1);

    // R4 discarded commands
    run_write(2 * PB + 5, 6, 200, 0, 0, 0, 0, 1, "R4 stop not after ack");
    run_write(7 * PB + 1, 3, 201, 0, 0, 0, 0, 2, "R4 restart discards");
    run_write(9 * PB + 4, 0, 202, 0, 0, 0, 0, 0, "R4 empty command");

    // R10 byte before address ignored
    we_cnt = 0;
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 8'h11, 0, 0, 0);
    cyc(0, 1, 10'h050, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 8'h22, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    wait_busy(cnt);
    exp_mem[16'h050] = 8'h22;
    check(we_cnt == 1, "R10 early byte dropped", we_cnt, 1);
    check_array("R10 early byte", 1'b0);

    // R6 strobes during busy ignored
    we_cnt = 0;
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 10'h0C3, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 8'h3C, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    exp_mem[16'h0C3] = 8'h3C;
    cyc(1, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 1, 10'h0A0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 8'h5A, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    wait_busy(cnt);
    check(cnt == WRC - 4, "R6 busy not extended", cnt, WRC - 4);
    check(we_cnt == 1, "R6 ignored strobes write nothing", we_cnt, 1);
    check_array("R6 array after ignored strobes", 1'b0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    wait_busy(cnt);
    check(cnt == 0, "R6 no retained command", cnt, 0);

    check(we_out == 0, "R5 writes only while busy", we_out, 0);
    finish_run();
  end
endmodule